// File: doc/BRIEF.md
# Receive FIFO with Status Tagging

This block sits between the serial receiver of an asynchronous serial port and the CPU read path. Each character that the receiver completes is stored in an eight-deep queue together with three error flags: break, framing and parity. A status byte combines the error flags of the oldest stored character (or, in sticky mode, of every character received since the last clear) with an overrun flag, a queue-full flag, a data-ready flag and two transmitter flags that are passed through from the transmit side.

A one-character holding stage stands in for the receive shift register. A character that arrives while the queue is full waits there. On the next CPU read it moves into the freed slot in the same cycle, so the queue stays full. If a further character arrives while the holding stage is still occupied, the waiting character and its flags are replaced and the overrun flag is set. A 4-bit command input provides a clear-errors command and a receiver-reset command.

Top module: `rx_status_fifo`

## Requirements
- R1: While reset is asserted and directly after it, status bits 7:4 and 1:0 are 0 and `rd_data` is 0.
- R2: Characters are read in arrival order. Up to DEPTH (8) characters are stored. `rd_data` takes the oldest character on the clock edge at which `rd_en` is sampled high with the queue non-empty.
- R3: `status[0]` (data ready) is 1 exactly when at least one character is stored. It rises only after a character is accepted and falls only when a read leaves the queue empty.
- R4: `status[1]` (full) is 1 exactly when all 8 slots are occupied. A read while a character waits in the holding stage leaves it at 1, because that character takes the freed slot in the same cycle.
- R5: A character that arrives while the queue is full and the holding stage is empty is kept in the holding stage. It is delivered after the 8 queued characters, with its flags.
- R6: A character that arrives while the queue is full and the holding stage is occupied, with no read in that cycle, sets `status[4]` (overrun). The held character and its flags are discarded and the new one takes its place.
- R7: Overrun is cleared only by command code 4'b0100. Receiver reset leaves it unchanged. A new overrun in the same cycle as the clear wins.
- R8: With `blk_mode`=0, `status[7:5]` = {break, framing, parity} of the oldest stored character, or 0 when the queue is empty.
- R9: With `blk_mode`=1, `status[7:5]` is the OR of the flags of every character that entered the queue since the last clear or receiver reset.
- R10: Command 4'b0100 clears the flags of all stored and held characters and the sticky accumulator. A character accepted in the same cycle keeps its own flags.
- R11: Command 4'b0010 (receiver reset) empties the queue and the holding stage and clears all flags. It ignores `rd_en` and `rx_valid` in that cycle and keeps `rd_data`.
- R12: A read of an empty queue changes neither `rd_data` nor any status bit.
- R13: `status[3]` equals `tx_empty` and `status[2]` equals `tx_ready`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Receiver completed a character this cycle |
| rx_data | input | DATA_W | Completed character |
| rx_brk | input | 1 | Break flag of the character |
| rx_frm | input | 1 | Framing-error flag of the character |
| rx_par | input | 1 | Parity-error flag of the character |
| rd_en | input | 1 | CPU read of the queue |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command: 4'b0100 clear errors, 4'b0010 receiver reset |
| blk_mode | input | 1 | 1 = sticky (block) error flags, 0 = per-character flags |
| tx_empty | input | 1 | Transmitter empty, passed to status bit 3 |
| tx_ready | input | 1 | Transmitter ready, passed to status bit 2 |
| rd_data | output | DATA_W | Last character read |
| status | output | 8 | {brk, frm, par, overrun, tx_empty, tx_ready, full, ready} |

## Verification
The cycle assertions check the local rules on every cycle: the holding stage is used only while the queue is full, the full flag holds across a read that drains the holding stage, overrun stays set until a clear and rises only on an arrival that meets an occupied holding stage, the sticky accumulator never loses a bit without a clear, and the queue count never overflows or underflows. The order of delivered characters, the loss of exactly the held character on overrun, the per-character versus sticky flag view, and the interaction of the commands with arrivals and reads in the same cycle can only be shown by the bench. It compares every output on every cycle against its own queue model, under directed sequences and random traffic.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rsf_flags_t;

   localparam int          RSF_CMD_W      = 4;
   localparam logic [3:0]  RSF_CMD_CLRERR = 4'b0100;
   localparam logic [3:0]  RSF_CMD_RXRST  = 4'b0010;

endpackage

// File: rtl/rsf_store.sv
module rsf_store
   import rsf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  rsf_flags_t        wr_flags,
   input  logic              pop,
   input  logic              clr_flags,
   output logic [DATA_W-1:0] head_data,
   output rsf_flags_t        head_flags,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   logic [DATA_W-1:0] mem_q [DEPTH];
   rsf_flags_t        flg   [DEPTH];
   logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
   logic [CW-1:0]     cnt_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_ptr_q] <= wr_data;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      rsf_flags_t slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    slot_q <= '0;
         else if (flush)                                slot_q <= '0;
         else if (wr_en && wr_ptr_q == AW'(i))          slot_q <= wr_flags;
         else if (clr_flags)                            slot_q <= '0;
      end
      assign flg[i] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (flush) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (wr_en) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop)   rd_ptr_q <= rd_ptr_q + 1'b1;
         cnt_q <= cnt_q + CW'(wr_en) - CW'(pop);
      end
   end

   assign head_data  = mem_q[rd_ptr_q];
   assign head_flags = flg[rd_ptr_q];
   assign count      = cnt_q;

   AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pop && !flush) |-> (cnt_q != CW'(DEPTH))); // R2
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |-> (cnt_q != '0)); // R2

endmodule

// File: rtl/rsf_hold.sv
module rsf_hold
   import rsf_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push_v,
   input  logic [DATA_W-1:0] push_data,
   input  rsf_flags_t        push_flags,
   input  logic              full,
   input  logic              pop,
   input  logic              clr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output rsf_flags_t        wr_flags,
   output logic              ovr
);
   logic              hold_v_q;
   logic [DATA_W-1:0] hold_d_q;
   rsf_flags_t        hold_f_q;
   logic              ovr_q;
   logic              move, direct, to_hold, ovr_set;

   assign move    = pop && hold_v_q;
   assign direct  = push_v && (!full || (pop && !hold_v_q));
   assign to_hold = push_v && !direct;
   assign ovr_set = to_hold && hold_v_q && !move;

   assign wr_en    = move || direct;
   assign wr_data  = move ? hold_d_q : push_data;
   assign wr_flags = move ? (clr ? '0 : hold_f_q) : push_flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v_q <= 1'b0;
         hold_d_q <= '0;
         hold_f_q <= '0;
      end else if (flush) begin
         hold_v_q <= 1'b0;
         hold_f_q <= '0;
      end else if (to_hold) begin
         hold_v_q <= 1'b1;
         hold_d_q <= push_data;
         hold_f_q <= push_flags;
      end else begin
         if (move) hold_v_q <= 1'b0;
         if (clr)  hold_f_q <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_q <= 1'b0;
      else if (ovr_set) ovr_q <= 1'b1;
      else if (clr)     ovr_q <= 1'b0;
   end

   assign ovr = ovr_q;

   AST_HOLD_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      hold_v_q |-> full); // R5
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !clr) |=> ovr_q); // R7
   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(push_v && hold_v_q && !pop)); // R6

endmodule

// File: rtl/rsf_errview.sv
module rsf_errview
   import rsf_pkg::*;
#(
   parameter bit BLOCK_EN = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush,
   input  logic       clr,
   input  logic       blk_mode,
   input  logic       nonempty,
   input  rsf_flags_t head_flags,
   input  logic       wr_en,
   input  rsf_flags_t wr_flags,
   output rsf_flags_t err
);
   rsf_flags_t head_view;
   assign head_view = nonempty ? head_flags : '0;

   if (BLOCK_EN) begin : g_block
      rsf_flags_t acc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     acc_q <= '0;
         else if (flush) acc_q <= '0;
         else            acc_q <= (clr ? '0 : acc_q) | (wr_en ? wr_flags : '0);
      end
      assign err = blk_mode ? acc_q : head_view;

      AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && !flush) |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R9
   end else begin : g_char_only
      logic unused_blk;
      assign unused_blk = ^{clk, rst_n, flush, clr, blk_mode, wr_en, wr_flags};
      assign err = head_view;
   end

endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
   import rsf_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 8,
   parameter bit BLOCK_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_brk,
   input  logic              rx_frm,
   input  logic              rx_par,
   input  logic              rd_en,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_code,
   input  logic              blk_mode,
   input  logic              tx_empty,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic [7:0]        status
);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
      $error("rx_status_fifo: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rx_status_fifo: DATA_W must be positive");
   end
   if (RSF_CMD_W != 4) begin : g_bad_cmd
      $error("rx_status_fifo: command width mismatch");
   end

   logic              flush, clr, push_v, pop, full, nonempty, ovr;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data, head_data;
   rsf_flags_t        wr_flags, head_flags, push_flags, err;
   logic [CW-1:0]     count;
   logic [DATA_W-1:0] rd_data_q;

   assign flush      = cmd_valid && (cmd_code == RSF_CMD_RXRST);
   assign clr        = cmd_valid && (cmd_code == RSF_CMD_CLRERR);
   assign push_v     = rx_valid && !flush;
   assign nonempty   = (count != '0);
   assign full       = (count == CW'(DEPTH));
   assign pop        = rd_en && nonempty && !flush;
   assign push_flags = '{brk: rx_brk, frm: rx_frm, par: rx_par};

   rsf_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push_v(push_v), .push_data(rx_data), .push_flags(push_flags),
      .full(full), .pop(pop), .clr(clr),
      .wr_en(wr_en), .wr_data(wr_data), .wr_flags(wr_flags), .ovr(ovr)
   );

   rsf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_en(wr_en), .wr_data(wr_data), .wr_flags(wr_flags),
      .pop(pop), .clr_flags(clr),
      .head_data(head_data), .head_flags(head_flags), .count(count)
   );

   rsf_errview #(.BLOCK_EN(BLOCK_EN)) u_err (
      .clk(clk), .rst_n(rst_n), .flush(flush), .clr(clr),
      .blk_mode(blk_mode), .nonempty(nonempty), .head_flags(head_flags),
      .wr_en(wr_en), .wr_flags(wr_flags), .err(err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rd_data_q <= '0;
      else if (pop) rd_data_q <= head_data;
   end

   assign rd_data = rd_data_q;
   assign status  = {err.brk, err.frm, err.par, ovr, tx_empty, tx_ready, full, nonempty};

   AST_FULL_HELD_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (status[1] && rx_valid && rd_en && !cmd_valid) ##0 (status[1]) |=> status[1]); // R4
   AST_EMPTY_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[0] && rd_en && !rx_valid && !cmd_valid) |=> ($stable(rd_data) && !status[0])); // R12
   AST_READY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> $past(rx_valid)); // R3

endmodule

// File: tb/rx_status_fifo_tb.sv
module rx_status_fifo_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       rx_valid, rx_brk, rx_frm, rx_par, rd_en, cmd_valid, blk_mode;
   logic       tx_empty, tx_ready;
   logic [7:0] rx_data;
   logic [3:0] cmd_code;
   logic [7:0] rd_data;
   logic [7:0] status;

   int checks = 0;
   int bad    = 0;
   bit done   = 0;

   always #10 clk = ~clk;   // 50 MHz

   rx_status_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_par(rx_par), .rd_en(rd_en),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .blk_mode(blk_mode),
      .tx_empty(tx_empty), .tx_ready(tx_ready), .rd_data(rd_data), .status(status)
   );

   // model: entry = {brk,frm,par,data}
   logic [10:0] mq[$];
   logic [10:0] hreg;
   bit          hv, movr;
   logic [2:0]  macc;
   logic [7:0]  mlast;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_status();
      logic [2:0] e;
      if (blk_mode) e = macc;
      else          e = (mq.size() > 0) ? mq[0][10:8] : 3'b000;
      return {e, movr, tx_empty, tx_ready, mq.size() == 8, mq.size() != 0};
   endfunction

   task automatic model(input bit pv, input logic [7:0] pd, input logic [2:0] pf,
                        input bit rd, input bit cv, input logic [3:0] cc);
      bit clr, popd, oset;
      if (cv && cc == 4'b0010) begin
         mq.delete(); hv = 0; hreg = '0; macc = '0;
         return;
      end
      clr  = cv && cc == 4'b0100;
      popd = rd && mq.size() > 0;
      oset = 0;
      if (popd) begin mlast = mq[0][7:0]; void'(mq.pop_front()); end
      if (clr) begin
         foreach (mq[i]) mq[i][10:8] = 3'b000;
         hreg[10:8] = 3'b000; macc = '0;
      end
      if (popd && hv) begin mq.push_back(hreg); macc |= hreg[10:8]; hv = 0; end
      if (pv) begin
         if (mq.size() < 8) begin mq.push_back({pf, pd}); macc |= pf; end
         else begin if (hv) oset = 1; hv = 1; hreg = {pf, pd}; end
      end
      if (oset) movr = 1; else if (clr) movr = 0;
   endtask

   task automatic cyc(input bit pv, input logic [7:0] pd, input logic [2:0] pf,
                      input bit rd, input bit cv, input logic [3:0] cc);
      logic [7:0] es;
      bit empty_rd;
      empty_rd = rd && mq.size() == 0 && !cv;
      rx_valid = pv; rx_data = pd; {rx_brk, rx_frm, rx_par} = pf;
      rd_en = rd; cmd_valid = cv; cmd_code = cc;
      tx_empty = 1'($urandom_range(1)); tx_ready = 1'($urandom_range(1));
      @(posedge clk);
      model(pv, pd, pf, rd, cv, cc);
      @(negedge clk);
      es = exp_status();
      chk("R3 ready bit", 32'(status[0]), 32'(es[0]));
      chk("R4 full bit", 32'(status[1]), 32'(es[1]));
      chk("R13 tx bits", 32'(status[3:2]), 32'(es[3:2]));
      chk("R6 overrun bit", 32'(status[4]), 32'(es[4]));
      chk(blk_mode ? "R9 sticky flags" : "R8 head flags", 32'(status[7:5]), 32'(es[7:5]));
      chk(empty_rd ? "R12 empty read data" : "R2 read data", 32'(rd_data), 32'(mlast));
   endtask

   task automatic idle(); cyc(0, 8'h00, 3'b000, 0, 0, 4'h0); endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; checks++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5eed));
      mq.delete(); hv = 0; hreg = '0; movr = 0; macc = '0; mlast = '0;
      rst_n = 0; rx_valid = 0; rx_data = 0; {rx_brk, rx_frm, rx_par} = 3'b000;
      rd_en = 0; cmd_valid = 0; cmd_code = 0; blk_mode = 0; tx_empty = 0; tx_ready = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset status", 32'(status & 8'hF3), 32'h0);
      chk("R1 reset rd_data", 32'(rd_data), 32'h0);
      rst_n = 1;
      idle();
      chk("R1 after reset", 32'(status & 8'hF3), 32'h0);

      // fill the queue, then the holding stage, then overrun (R5, R6)
      for (int i = 0; i < 8; i++) cyc(1, 8'(8'h10 + i), 3'(i), 0, 0, 4'h0);
      chk("R4 full after 8", 32'(status[1]), 32'h1);
      cyc(1, 8'hA0, 3'b101, 0, 0, 4'h0);
      chk("R5 held, no overrun", 32'(status[4]), 32'h0);
      cyc(1, 8'hA1, 3'b011, 0, 0, 4'h0);
      chk("R6 overrun set", 32'(status[4]), 32'h1);
      cyc(0, 8'h00, 3'b000, 1, 0, 4'h0);
      chk("R4 full kept on held read", 32'(status[1]), 32'h1);
      chk("R2 first read", 32'(rd_data), 32'h10);
      for (int i = 0; i < 8; i++) cyc(0, 8'h00, 3'b000, 1, 0, 4'h0);
      chk("R5 held char last", 32'(rd_data), 32'hA1);
      chk("R3 empty after drain", 32'(status[0]), 32'h0);
      cyc(0, 8'h00, 3'b000, 1, 0, 4'h0);
      chk("R12 empty read keeps data", 32'(rd_data), 32'hA1);

      // receiver reset keeps overrun, clear removes it (R7, R11)
      for (int i = 0; i < 3; i++) cyc(1, 8'(8'h30 + i), 3'b111, 0, 0, 4'h0);
      cyc(0, 8'h00, 3'b000, 1, 1, 4'b0010);
      chk("R11 flushed", 32'(status[1:0]), 32'h0);
      chk("R11 rd_data kept", 32'(rd_data), 32'hA1);
      chk("R7 overrun survives rx reset", 32'(status[4]), 32'h1);
      cyc(0, 8'h00, 3'b000, 0, 1, 4'b0100);
      chk("R7 overrun cleared", 32'(status[4]), 32'h0);

      // block mode sticky flags and clear (R9, R10)
      blk_mode = 1;
      cyc(1, 8'h41, 3'b100, 0, 0, 4'h0);
      cyc(1, 8'h42, 3'b001, 0, 0, 4'h0);
      cyc(0, 8'h00, 3'b000, 1, 0, 4'h0);
      cyc(0, 8'h00, 3'b000, 1, 0, 4'h0);
      chk("R9 sticky after reads", 32'(status[7:5]), 32'h5);
      cyc(1, 8'h43, 3'b010, 0, 1, 4'b0100);
      chk("R10 clear keeps new char flags", 32'(status[7:5]), 32'h2);
      blk_mode = 0;
      chk("R10 head flags of new char", 32'(status[7:5]), 32'h2);
      cyc(0, 8'h00, 3'b000, 1, 0, 4'h0);

      // random traffic in phases
      for (int ph = 0; ph < 40; ph++) begin
         int pp, rp;
         pp = (ph % 2 == 0) ? 80 : 30;
         rp = (ph % 2 == 0) ? 25 : 70;
         blk_mode = 1'($urandom_range(1));
         for (int k = 0; k < 80; k++) begin
            bit pv, rd, cv;
            logic [3:0] cc;
            pv = ($urandom_range(99) < pp);
            rd = ($urandom_range(99) < rp);
            cv = ($urandom_range(99) < 4);
            cc = ($urandom_range(3) == 0) ? 4'b0010 : 4'b0100;
            cyc(pv, 8'($urandom), 3'($urandom), rd, cv, cc);
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule